// File: doc/BRIEF.md
# Bus-Master Write Command Sequencer

This block is the write half of a 32-bit bus initiator. A DMA engine hands it one request: a byte start address, which is taken as dword aligned, and a length in dwords. The block splits the request into bus write transactions. For each transaction it picks either a plain memory write or a memory write-and-invalidate. Each transaction is announced with a command, an address and a planned data-phase count. The block then counts the data phases that the bus reports as complete. The target may end a transaction early at any data phase, and the block treats that as an ordinary event. It works out where the next transaction begins and reissues whatever data remains.

Write-and-invalidate is issued only when the current address sits on a cacheline boundary and at least one whole cacheline of data remains. Such a transaction is always planned as a whole number of cachelines. When a target stops a transaction partway through a cacheline, the next transaction is therefore a plain write that runs only as far as the next boundary. After that boundary, full-line transactions may use write-and-invalidate again. The cacheline size is 8 or 16 dwords. It is sampled when a request is accepted.

Top module: `wr_cmd_sequencer`

## Requirements
- R1: `req_ready` is high only while idle, and a request is taken on a cycle with `req_valid` and `req_ready` both high. While a request is in progress, `req_ready` stays low and `req_valid` has no effect.
- R2: Command 4'b1111 (write-and-invalidate) is chosen only when the current dword address is a multiple of the line size and the remaining count is at least one line. Its length is the remaining count rounded down to whole lines, capped at `MAX_BURST`.
- R3: Otherwise command 4'b0111 (plain write) is used. From an address off a line boundary, the length is the smaller of the remaining count and the dwords left to the next boundary. From an aligned address with less than a line remaining, the length is the remaining count.
- R4: `line_sel` 0 selects 8-dword lines and 1 selects 16-dword lines. It is sampled when a request is taken, and later changes have no effect until the next request.
- R5: Each transaction is announced by a one-cycle `txn_start` pulse. The pulse comes two cycles after acceptance, or two cycles after the cycle in which the previous transaction ended. `txn_cmd`, `txn_addr` and `txn_len` stay constant until that transaction ends.
- R6: A transaction ends on the cycle its `dphase_done` count reaches `txn_len`, or on any cycle with `tgt_disc` high. A `dphase_done` in that same cycle still counts.
- R7: After a transaction ends, the next address is its start address plus 4 times the completed data phases, and the remaining count falls by the same amount. A disconnect with no completed phase reissues the same address.
- R8: A restart after a disconnect inside a cacheline uses a plain write up to the next line boundary. Later transactions covering whole lines use write-and-invalidate again.
- R9: `done` pulses for one cycle, in the cycle after the one in which the last dword's data phase completes. A zero-length request produces `done` in the cycle after acceptance and no transaction.
- R10: After reset, `req_ready` is 1, and `txn_start` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | DMA request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Byte start address (bits 1:0 ignored) |
| req_len | input | LEN_W | Request length in dwords |
| line_sel | input | 1 | Cacheline size: 0 = 8 dwords, 1 = 16 dwords |
| txn_start | output | 1 | One-cycle pulse announcing a transaction |
| txn_cmd | output | 4 | Bus command: 4'b0111 plain write, 4'b1111 write-and-invalidate |
| txn_addr | output | ADDR_W | Transaction start byte address |
| txn_len | output | BURST_W | Planned number of data phases |
| dphase_done | input | 1 | One data phase completed this cycle |
| tgt_disc | input | 1 | Target ended the current transaction this cycle |
| done | output | 1 | One-cycle pulse when the whole request has completed |

## Verification
A wrong remaining count or cursor address shows up in the very next `txn_start`, as a wrong address, length or command. It therefore surfaces within two cycles of the transaction that caused it. A sampled line size that drifts during a request shows as write-and-invalidate lengths that are not multiples of the line, or as plain writes where whole lines are available. A phase counter that slips shows either as a transaction that ends one phase early or late, or as `done` arriving in the wrong cycle. A reference model of the target, driven with disconnects at chosen phase counts, compares every announced transaction and the `done` cycle against values it derives on its own.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

  typedef enum logic [3:0] {
    CMD_MEM_WR     = 4'b0111,
    CMD_MEM_WR_INV = 4'b1111
  } bus_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PLAN = 2'd1,
    ST_DATA = 2'd2
  } seq_state_e;

endpackage

// File: rtl/wcs_planner.sv
module wcs_planner
  import wcs_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_BURST = 32,
  parameter int BURST_W   = $clog2(MAX_BURST + 1)
) (
  input  logic [ADDR_W-1:0]  cur_addr,
  input  logic [LEN_W-1:0]   remain,
  input  logic               line16,
  output bus_cmd_e           cmd,
  output logic [BURST_W-1:0] len
);

  logic [4:0]       line_dw;
  logic [3:0]       off;
  logic [4:0]       to_edge;
  logic [LEN_W-1:0] whole;
  logic             aligned;

  // offset of the cursor inside its cacheline, in dwords
  assign line_dw = line16 ? 5'd16 : 5'd8;
  assign off     = line16 ? cur_addr[5:2] : {1'b0, cur_addr[4:2]};
  assign aligned = (off == 4'd0);
  assign to_edge = line_dw - {1'b0, off};
  assign whole   = line16 ? {remain[LEN_W-1:4], 4'b0000} : {remain[LEN_W-1:3], 3'b000};

  always_comb begin
    if (aligned && (remain >= LEN_W'(line_dw))) begin
      cmd = CMD_MEM_WR_INV;
      len = (whole > LEN_W'(MAX_BURST)) ? BURST_W'(MAX_BURST) : BURST_W'(whole);
    end else begin
      cmd = CMD_MEM_WR;
      if (!aligned && (remain > LEN_W'(to_edge))) len = BURST_W'(to_edge);
      else                                        len = BURST_W'(remain);
    end
  end

endmodule

// File: rtl/wcs_phase_ctr.sv
module wcs_phase_ctr #(
  parameter int BURST_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               in_data,
  input  logic               phase_ok,
  input  logic               disc,
  input  logic [BURST_W-1:0] limit,
  output logic               finish,
  output logic [BURST_W-1:0] completed
);

  logic [BURST_W-1:0] count;

  assign completed = phase_ok ? (count + BURST_W'(1)) : count;
  assign finish    = in_data && (disc || (phase_ok && (completed == limit)));

  always_ff @(posedge clk) begin
    if (rst || clear)              count <= '0;
    else if (in_data && phase_ok)  count <= count + BURST_W'(1);
  end

  // R6: the counter never reaches the planned length while still in the data state
  a_r6_count_below_limit: assert property (@(posedge clk) disable iff (rst)
    in_data |-> (count < limit));

endmodule

// File: rtl/wr_cmd_sequencer.sv
module wr_cmd_sequencer
  import wcs_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_BURST = 32,
  parameter int BURST_W   = $clog2(MAX_BURST + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic               line_sel,
  output logic               txn_start,
  output logic [3:0]         txn_cmd,
  output logic [ADDR_W-1:0]  txn_addr,
  output logic [BURST_W-1:0] txn_len,
  input  logic               dphase_done,
  input  logic               tgt_disc,
  output logic               done
);

  seq_state_e         state;
  logic [ADDR_W-1:0]  addr_q;
  logic [LEN_W-1:0]   rem_q;
  logic               line16_q;
  bus_cmd_e           plan_cmd;
  logic [BURST_W-1:0] plan_len;
  logic               finish;
  logic [BURST_W-1:0] completed;
  logic               accept;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  wcs_planner #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_BURST(MAX_BURST), .BURST_W(BURST_W)
  ) u_plan (
    .cur_addr(addr_q), .remain(rem_q), .line16(line16_q),
    .cmd(plan_cmd), .len(plan_len)
  );

  wcs_phase_ctr #(.BURST_W(BURST_W)) u_ctr (
    .clk(clk), .rst(rst), .clear(state == ST_PLAN), .in_data(state == ST_DATA),
    .phase_ok(dphase_done), .disc(tgt_disc), .limit(txn_len),
    .finish(finish), .completed(completed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      addr_q    <= '0;
      rem_q     <= '0;
      line16_q  <= 1'b0;
      txn_start <= 1'b0;
      txn_cmd   <= CMD_MEM_WR;
      txn_addr  <= '0;
      txn_len   <= '0;
      done      <= 1'b0;
    end else begin
      txn_start <= 1'b0;
      done      <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          addr_q   <= {req_addr[ADDR_W-1:2], 2'b00};
          rem_q    <= req_len;
          line16_q <= line_sel;
          if (req_len == '0) done  <= 1'b1;
          else               state <= ST_PLAN;
        end
        ST_PLAN: begin
          txn_start <= 1'b1;
          txn_cmd   <= plan_cmd;
          txn_addr  <= addr_q;
          txn_len   <= plan_len;
          state     <= ST_DATA;
        end
        ST_DATA: if (finish) begin
          addr_q <= addr_q + {{(ADDR_W-BURST_W-2){1'b0}}, completed, 2'b00};
          rem_q  <= rem_q - LEN_W'(completed);
          if (rem_q == LEN_W'(completed)) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            state <= ST_PLAN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---- checker state, kept apart from the datapath ----
  logic [ADDR_W-1:0] chk_next;
  logic              chk_have;
  logic              chk_mid;
  logic [3:0]        chk_off;

  assign chk_off = line16_q ? chk_next[5:2] : {1'b0, chk_next[4:2]};

  always_ff @(posedge clk) begin
    if (rst || accept) begin
      chk_next <= '0;
      chk_have <= 1'b0;
      chk_mid  <= 1'b0;
    end else if (finish) begin
      chk_next <= txn_addr + ADDR_W'({completed, 2'b00});
      chk_have <= 1'b1;
      chk_mid  <= (txn_cmd == CMD_MEM_WR_INV) &&
                  ((line16_q ? (txn_addr[5:2] + completed[3:0]) != 4'd0
                             : (txn_addr[4:2] + completed[2:0]) != 3'd0));
    end
  end

  // R2: write-and-invalidate starts on a line and spans whole lines
  a_r2_mwi_whole_lines: assert property (@(posedge clk) disable iff (rst)
    (txn_start && txn_cmd == CMD_MEM_WR_INV) |->
      ((line16_q ? (txn_addr[5:2] == 4'd0 && txn_len[3:0] == 4'd0)
                 : (txn_addr[4:2] == 3'd0 && txn_len[2:0] == 3'd0)) && txn_len != '0));

  // R5: announced fields hold for the life of the transaction
  a_r5_fields_stable: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA && !txn_start) |->
      ($stable(txn_addr) && $stable(txn_cmd) && $stable(txn_len)));

  // R4: sampled line size does not move during a request
  a_r4_line_held: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(line16_q));

  // R7: each restart picks up where the previous transaction stopped
  a_r7_resume_addr: assert property (@(posedge clk) disable iff (rst)
    (txn_start && chk_have) |-> (txn_addr == chk_next));

  // R8: a restart inside a cacheline is a plain write
  a_r8_midline_plain: assert property (@(posedge clk) disable iff (rst)
    (txn_start && chk_mid) |-> (txn_cmd == CMD_MEM_WR && chk_off != 4'd0));

endmodule

// File: tb/wr_cmd_sequencer_tb.sv
module wr_cmd_sequencer_tb;
  localparam int ADDR_W    = 32;
  localparam int LEN_W     = 16;
  localparam int MAX_BURST = 32;
  localparam int BURST_W   = $clog2(MAX_BURST + 1);

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               req_valid = 1'b0;
  logic               req_ready;
  logic [ADDR_W-1:0]  req_addr = '0;
  logic [LEN_W-1:0]   req_len = '0;
  logic               line_sel = 1'b0;
  logic               txn_start;
  logic [3:0]         txn_cmd;
  logic [ADDR_W-1:0]  txn_addr;
  logic [BURST_W-1:0] txn_len;
  logic               dphase_done = 1'b0;
  logic               tgt_disc = 1'b0;
  logic               done;

  int n_checks = 0;
  int n_fail   = 0;
  int disc_q[$];

  always #4 clk = ~clk;

  wr_cmd_sequencer #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_BURST(MAX_BURST), .BURST_W(BURST_W)
  ) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .line_sel(line_sel),
    .txn_start(txn_start), .txn_cmd(txn_cmd), .txn_addr(txn_addr), .txn_len(txn_len),
    .dphase_done(dphase_done), .tgt_disc(tgt_disc), .done(done)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // reference policy, integers only
  function automatic void exp_plan(input int addr, input int rem, input int line,
                                   output int cmd, output int len);
    int off;
    off = (addr / 4) % line;
    if (off == 0 && rem >= line) begin
      cmd = 15;
      len = (rem / line) * line;
      if (len > MAX_BURST) len = MAX_BURST;
    end else begin
      cmd = 7;
      if (off != 0 && rem > line - off) len = line - off;
      else                              len = rem;
    end
  endfunction

  task automatic run_req(input int addr, input int len, input bit l16,
                         input bit hold_busy, input bit flip_line, input bit waits);
    int line, cur, rem, ecmd, elen, d, n, w;
    bit dsc;
    @(negedge clk);
    chk("R1", "req_ready idle", req_ready, 1);
    req_valid = 1'b1;
    req_addr  = ADDR_W'(addr);
    req_len   = LEN_W'(len);
    line_sel  = l16;
    @(negedge clk);
    if (hold_busy) begin
      req_addr = 32'h0BAD_0000;
      req_len  = 16'd3;
    end else begin
      req_valid = 1'b0;
    end
    if (flip_line) line_sel = ~l16;
    line = l16 ? 16 : 8;
    cur  = addr;
    rem  = len;
    if (len == 0) begin
      chk("R9", "done after zero-length", done, 1);
      chk("R9", "no txn for zero-length", txn_start, 0);
      return;
    end
    while (rem > 0) begin
      w = 0;
      while (!txn_start && w < 20) begin
        @(negedge clk);
        w++;
      end
      chk("R5", "txn_start gap", w, 1);
      exp_plan(cur, rem, line, ecmd, elen);
      chk(ecmd == 15 ? "R2" : "R3", "txn_cmd", txn_cmd, ecmd);
      chk("R7", "txn_addr", txn_addr, cur);
      chk(ecmd == 15 ? "R2" : "R3", "txn_len", txn_len, elen);
      chk("R1", "req_ready while busy", req_ready, 0);
      d   = (disc_q.size() > 0) ? disc_q.pop_front() : -1;
      dsc = (d >= 0 && d < elen);
      n   = dsc ? d : elen;
      if (n == 0) begin
        tgt_disc = 1'b1;
        @(negedge clk);
        tgt_disc = 1'b0;
      end else begin
        for (int i = 0; i < n; i++) begin
          if (waits && (i % 2 == 1)) @(negedge clk);
          dphase_done = 1'b1;
          if (i == n - 1) begin
            tgt_disc = dsc;
            if (rem == n) req_valid = 1'b0;
          end
          @(negedge clk);
          dphase_done = 1'b0;
          tgt_disc    = 1'b0;
        end
      end
      cur += 4 * n;
      rem -= n;
      chk("R9", "done timing", done, (rem == 0) ? 1 : 0);
    end
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", "req_ready reset", req_ready, 1);
    chk("R10", "txn_start reset", txn_start, 0);
    chk("R10", "done reset", done, 0);

    run_req(32'h1000, 32, 1'b1, 0, 0, 0);            // R2 single full burst
    run_req(32'h2000, 80, 1'b1, 0, 0, 1);            // R2 capped bursts
    run_req(32'h3014, 20, 1'b0, 0, 0, 0);            // R3 unaligned head and tail
    disc_q = '{5};
    run_req(32'h4000, 48, 1'b1, 0, 0, 0);            // R8 mid-line disconnect
    disc_q = '{16};
    run_req(32'h5000, 32, 1'b0, 0, 0, 1);            // R6 disconnect on boundary
    disc_q = '{0};
    run_req(32'h6000, 8, 1'b0, 0, 0, 0);             // R7 zero-phase disconnect
    disc_q = '{3};
    run_req(32'h7004, 10, 1'b0, 0, 0, 1);            // R7 disconnect in plain write
    run_req(32'h8000, 5, 1'b1, 0, 0, 0);             // R3 short aligned
    run_req(32'h8800, 0, 1'b1, 0, 0, 0);             // R9 zero length
    run_req(32'h9000, 24, 1'b0, 1, 1, 0);            // R1 busy request, R4 line flip
    disc_q = '{2, 7};
    run_req(32'hA008, 40, 1'b1, 0, 0, 1);            // R8 repeated disconnects
    @(negedge clk);
    chk("R1", "idle after busy request", req_ready, 1);
    chk("R1", "no extra txn", txn_start, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule